// File: doc/BRIEF.md
# Gigabit PCS Management Registers

This block holds the control and status registers of a PCS that runs only at gigabit speed and only in full duplex. A management agent reaches the registers through a simple synchronous port. The agent presents an address with either a write enable and write data, or a read strobe. The block turns control writes into PCS-side controls. Some of these are levels: auto-negotiation enable, isolate, power-down and loopback. Others are single-cycle commands: PCS reset and restart of auto-negotiation. The command bits clear themselves, so they always read back as 0.

The status register reports fixed capability flags and a link bit. The link bit latches low. Any cycle in which the live link indication is invalid pulls the bit to 0, and it stays 0 until the status register is read. A read returns the latched value, and on the next clock the bit is reloaded from the live link. While isolate is set, the PCS reset output is held asserted.

Read data is registered. It changes only at a clock edge where the read strobe is sampled high, and otherwise holds its value.

Top module: `gpcs_mgmt_regs`

## Requirements
- R1: After the active-low asynchronous reset, the control register reads 0x1140, the status register reads 0x0009, an_en_o is 1, and pcs_rst_o, an_restart_o, isolate_o, pwr_down_o and loopback_o are 0.
- R2: The control register is at address 0. Only bits 14 (loopback), 12 (auto-negotiation enable), 11 (power-down) and 10 (isolate) are stored. Bits 8 and 6 always read 1, and all other bits read 0, so writing 0xFFFF reads back 0x5D40 and writing 0x0000 reads back 0x0140.
- R3: Writing 1 to control bit 15 raises pcs_rst_o for exactly the one cycle after the write edge. Bit 15 reads back as 0.
- R4: Writing 1 to control bit 9 raises an_restart_o for exactly the one cycle after the write edge. Bit 9 reads back as 0.
- R5: While control bit 10 is 1, pcs_rst_o stays 1 on every cycle.
- R6: an_en_o, pwr_down_o, loopback_o and isolate_o equal the stored control bits 12, 11, 14 and 10 from the cycle after the write.
- R7: The status register is at address 1. Its bits 0 and 3 read 1, and bit 1 and bits 15 to 4 read 0.
- R8: Status bit 2 goes to 0 after any cycle with link_ok_i low. It stays 0 until the status register is read, even if the link recovers.
- R9: A status read reloads bit 2 from link_ok_i at the read edge. If link_ok_i is low during the read cycle, the bit stays 0.
- R10: Writes to any address other than 0 are ignored, and reads of those addresses return 0.
- R11: rd_data_o updates one clock after a sampled read strobe and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| link_ok_i | input | 1 | Live link-valid indication |
| pcs_rst_o | output | 1 | PCS reset (pulse or held by isolate) |
| an_restart_o | output | 1 | Auto-negotiation restart pulse |
| an_en_o | output | 1 | Auto-negotiation enable level |
| isolate_o | output | 1 | Isolate level |
| pwr_down_o | output | 1 | Power-down level |
| loopback_o | output | 1 | Loopback level |

## Verification
Control writes use 0xFFFF, 0x0000 and single command bits. The all-ones write separates stored bits from fixed constants, and the all-zeros write exposes constants that were stored by mistake. The single-bit writes show whether a command produces one pulse, a stuck level or nothing, and whether it reads back as 0. The link input is exercised with three patterns: a drop that recovers before any read, a stable link across consecutive reads, and a drop that lasts only for the read cycle. Together these distinguish a latching bit from a live one, a clear-on-read from no clear, and drop-over-read priority from read-over-drop. A write to an unmapped address followed by reads shows whether the decode leaks.

// File: rtl/gpcs_regs_pkg.sv
package gpcs_regs_pkg;
  localparam int REG_W = 16;

  localparam int BIT_PCS_RST  = 15;
  localparam int BIT_LOOPBACK = 14;
  localparam int BIT_AN_EN    = 12;
  localparam int BIT_PWR_DOWN = 11;
  localparam int BIT_ISOLATE  = 10;
  localparam int BIT_AN_RST   = 9;
  localparam int BIT_LINK     = 2;

  // stored control bits, their reset values, and fixed read-as-one bits
  localparam logic [REG_W-1:0] CTRL_RW_MASK = 16'h5C00;
  localparam logic [REG_W-1:0] CTRL_RST_VAL = 16'h1000;
  localparam logic [REG_W-1:0] CTRL_CONST   = 16'h0140;
  localparam logic [REG_W-1:0] STAT_CONST   = 16'h0009;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/gpcs_ctrl_reg.sv
module gpcs_ctrl_reg
  import gpcs_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_q_o,
  output logic             rst_pulse_o,
  output logic             an_restart_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (CTRL_RW_MASK[i]) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ctrl_q_o[i] <= CTRL_RST_VAL[i];
        else if (wr_i) ctrl_q_o[i] <= wdata_i[i];
      end
    end else begin : g_ro
      assign ctrl_q_o[i] = 1'b0;
    end
  end

  // self-clearing commands: one cycle per write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pulse_o  <= 1'b0;
      an_restart_o <= 1'b0;
    end else begin
      rst_pulse_o  <= wr_i & wdata_i[BIT_PCS_RST];
      an_restart_o <= wr_i & wdata_i[BIT_AN_RST];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[8:0], wdata_i[13]};
endmodule

// File: rtl/gpcs_link_latch.sv
module gpcs_link_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_ok_i,
  input  logic clr_i,
  output logic link_o
);
  // read reloads from live link; a drop in the read cycle still wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    link_o <= 1'b0;
    else if (clr_i) link_o <= link_ok_i;
    else            link_o <= link_o & link_ok_i;
  end
endmodule

// File: rtl/gpcs_rd_mux.sv
module gpcs_rd_mux
  import gpcs_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic             link_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    unique case (sel_i)
      SEL_CTRL: rd_d = CTRL_CONST | ctrl_i;
      SEL_STAT: begin
        rd_d           = STAT_CONST;
        rd_d[BIT_LINK] = link_i;
      end
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= rd_d;
  end
endmodule

// File: rtl/gpcs_mgmt_regs.sv
module gpcs_mgmt_regs
  import gpcs_regs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              link_ok_i,
  output logic              pcs_rst_o,
  output logic              an_restart_o,
  output logic              an_en_o,
  output logic              isolate_o,
  output logic              pwr_down_o,
  output logic              loopback_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  reg_sel_e         sel;
  logic [REG_W-1:0] ctrl_q;
  logic             rst_pulse;
  logic             link_lat;

  always_comb begin
    if (addr_i == CTRL_A)      sel = SEL_CTRL;
    else if (addr_i == STAT_A) sel = SEL_STAT;
    else                       sel = SEL_NONE;
  end

  gpcs_ctrl_reg u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_en_i && sel == SEL_CTRL),
    .wdata_i      (wr_data_i),
    .ctrl_q_o     (ctrl_q),
    .rst_pulse_o  (rst_pulse),
    .an_restart_o (an_restart_o)
  );

  gpcs_link_latch u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_ok_i (link_ok_i),
    .clr_i     (rd_en_i && sel == SEL_STAT),
    .link_o    (link_lat)
  );

  gpcs_rd_mux u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_en_i),
    .sel_i     (sel),
    .ctrl_i    (ctrl_q),
    .link_i    (link_lat),
    .rd_data_o (rd_data_o)
  );

  assign an_en_o    = ctrl_q[BIT_AN_EN];
  assign isolate_o  = ctrl_q[BIT_ISOLATE];
  assign pwr_down_o = ctrl_q[BIT_PWR_DOWN];
  assign loopback_o = ctrl_q[BIT_LOOPBACK];
  // isolate holds the PCS in reset
  assign pcs_rst_o  = rst_pulse | isolate_o;
endmodule

// File: rtl/gpcs_mgmt_regs_chk.sv
module gpcs_mgmt_regs_chk #(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [15:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [15:0]       rd_data_o,
  input logic              link_ok_i,
  input logic              pcs_rst_o,
  input logic              an_restart_o,
  input logic              isolate_o
);
  logic wr_ctrl, rd_stat;
  assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(CTRL_ADDR);
  assign rd_stat = rd_en_i && addr_i == ADDR_W'(STAT_ADDR);

  assert_rst_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wr_data_i[15]) |=> pcs_rst_o);

  assert_restart_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |-> $past(wr_ctrl && wr_data_i[9]));

  assert_isolate_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolate_o |-> pcs_rst_o);

  assert_isolate_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> isolate_o == $past(wr_data_i[10]));

  assert_stat_const_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |=> (rd_data_o[15:4] == 12'h000 && rd_data_o[3] && !rd_data_o[1] && rd_data_o[0]));

  assert_link_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !$past(link_ok_i)) |=> !rd_data_o[2]);

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  logic unused_chk;
  assign unused_chk = ^{wr_data_i[14:11], wr_data_i[8:0]};
endmodule

bind gpcs_mgmt_regs gpcs_mgmt_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .link_ok_i(link_ok_i), .pcs_rst_o(pcs_rst_o), .an_restart_o(an_restart_o),
  .isolate_o(isolate_o)
);

// File: tb/gpcs_mgmt_regs_bench.sv
`timescale 1ns/1ps
module gpcs_mgmt_regs_bench;
  localparam int AW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic [15:0]   wr_data_i = '0;
  logic          rd_en_i = 1'b0;
  logic [15:0]   rd_data_o;
  logic          link_ok_i = 1'b1;
  logic          pcs_rst_o, an_restart_o, an_en_o, isolate_o, pwr_down_o, loopback_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  gpcs_mgmt_regs #(.ADDR_W(AW)) u_gpcs_mgmt_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .link_ok_i(link_ok_i), .pcs_rst_o(pcs_rst_o), .an_restart_o(an_restart_o),
    .an_en_o(an_en_o), .isolate_o(isolate_o), .pwr_down_o(pwr_down_o),
    .loopback_o(loopback_o)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // driver: issue read, push expectation, optionally drop link for that cycle only
  task automatic rd_l(input logic [AW-1:0] a, input logic [15:0] e, input string tag, input logic lnk);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1; link_ok_i = lnk;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0; link_ok_i = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    rd_l(a, e, tag, 1'b1);
  endtask

  // monitor: compare registered read data after each sampled strobe
  initial begin
    forever begin
      @(posedge clk_i);
      if (rd_en_i) begin
        @(negedge clk_i);
        if (exp_q.size() == 0) check("R11 unexpected read", rd_data_o, 16'hxxxx);
        else check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 an_en", {15'd0, an_en_o}, 16'd1);
    check("R1 levels", {10'd0, pcs_rst_o, an_restart_o, isolate_o, pwr_down_o, loopback_o, 1'b0}, 16'd0);
    rd(0, 16'h1140, "R1 ctrl reset");
    rd(1, 16'h0009, "R1 R7 status reset");
    rd(1, 16'h000D, "R9 reload after read");

    // R3 reset pulse
    wr(0, 16'h9000);
    check("R3 pulse high", {15'd0, pcs_rst_o}, 16'd1);
    @(negedge clk_i);
    check("R3 pulse low", {15'd0, pcs_rst_o}, 16'd0);
    rd(0, 16'h1140, "R3 bit15 reads 0");

    // R4 restart pulse
    wr(0, 16'h1200);
    check("R4 pulse high", {15'd0, an_restart_o}, 16'd1);
    @(negedge clk_i);
    check("R4 pulse low", {15'd0, an_restart_o}, 16'd0);
    rd(0, 16'h1140, "R4 bit9 reads 0");

    // R2 R5 R6 all ones
    wr(0, 16'hFFFF);
    check("R6 levels set", {12'd0, an_en_o, pwr_down_o, loopback_o, isolate_o}, 16'h000F);
    for (int i = 0; i < 4; i++) begin
      check("R5 held reset", {15'd0, pcs_rst_o}, 16'd1);
      @(negedge clk_i);
    end
    rd(0, 16'h5D40, "R2 write ones");

    wr(0, 16'h0000);
    check("R6 levels clear", {12'd0, an_en_o, pwr_down_o, loopback_o, isolate_o}, 16'h0000);
    check("R5 released", {15'd0, pcs_rst_o}, 16'd0);
    rd(0, 16'h0140, "R2 write zeros");
    wr(0, 16'h1000);

    // R10 unmapped address
    wr(2, 16'hFFFF);
    check("R10 no side effect", {12'd0, an_en_o, pwr_down_o, loopback_o, isolate_o}, 16'h0008);
    rd(0, 16'h1140, "R10 ctrl intact");
    rd(2, 16'h0000, "R10 unmapped read");

    // R8 drop then recover before read
    @(negedge clk_i); link_ok_i = 1'b0;
    repeat (2) @(negedge clk_i);
    link_ok_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(1, 16'h0009, "R8 latched low");
    rd(1, 16'h000D, "R9 cleared by read");

    // R9 drop in the read cycle only
    rd_l(1, 16'h000D, "R9 drop during read", 1'b0);
    rd(1, 16'h0009, "R9 drop wins over read");
    rd(1, 16'h000D, "R9 recovered");

    // R11 hold while idle
    wr(0, 16'h5C00);
    repeat (3) @(negedge clk_i);
    check("R11 hold", rd_data_o, 16'h000D);

    repeat (3) @(negedge clk_i);
    check("R11 reads drained", 16'(exp_q.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule